// File: doc/BRIEF.md
# Front-End Stack Pointer Delta Tracker

This block sits beside the decoders and follows the stack pointer for push, pop, call and return operations without issuing any stack-pointer update micro-ops to the execution core. The core keeps a base stack-pointer value, named here by a small version number, that only changes when the front end folds its pending offset into it. The block itself holds a narrow signed delta. For every stack operation it reports the delta as it stood just before that operation, so the execution side can form each address as the base plus that offset.

Up to three decoded slots arrive per cycle, and they are processed in program order. Each slot sees the delta left behind by the slots ahead of it. Some instructions need the architectural stack pointer itself. For these, and for any step that would overflow the delta, the block raises a sync request on that slot. The request carries the delta to be added into the base; the delta restarts from zero and the base version advances.

All of this happens under speculation. A branch may therefore checkpoint the state into one of eight tag-indexed slots, and a later flush with that tag restores the delta and the version in a single cycle. A full flush returns the delta to zero.

Top module: `stack_delta_tracker`

## Requirements
- R1: Slot kind encoding is 3 bits: 1 push, 2 pop, 3 call, 4 return, 5 stack-pointer use. Push and call lower the delta by 4, and pop and return raise it by 4. None of these raises a sync unless R4 applies.
- R2: Slots are processed in lane order 0, 1, 2. Each stack operation's offset output equals the delta just before its own update, which already includes the updates of the lower lanes in the same cycle. The stored delta after the clock edge is the value left after lane 2.
- R3: A valid stack-pointer-use slot (kind 5) asserts that lane's sync flag. Its sync amount is the running delta at that lane and its offset is zero. The running delta then restarts at zero for the later lanes.
- R4: The delta is an 8-bit signed value. A push or call that meets a running delta of -128, or a pop or return that meets +124, first raises a sync with the running delta as the amount. The step is then applied from zero, and the slot's offset output reads zero.
- R5: The 4-bit base version advances by the number of sync flags raised in the cycle, modulo 16, and is otherwise unchanged unless R7 applies.
- R6: Invalid slots, and valid slots with kinds 0, 6 or 7, leave the delta unchanged. They show an offset of zero and raise no sync.
- R7: A checkpoint with a tag stores the delta and the version reached at the end of that cycle. A flush with a tag (flush asserted, full-flush deasserted) loads both back from that entry at the next edge, and the slots of the flush cycle are ignored.
- R8: A full flush clears the delta to zero and keeps the base version. The slots of that cycle are ignored.
- R9: Reset clears the delta, the version and every checkpoint entry, so a flush to a never-written tag gives delta 0 and version 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| slotValid | input | 3 | Per-lane slot valid |
| slotKind | input | 9 | Per-lane 3-bit kind code, lane n in bits 3n+2..3n |
| ckptValid | input | 1 | Take a checkpoint this cycle |
| ckptTag | input | 3 | Checkpoint entry index |
| flushValid | input | 1 | Flush this cycle |
| flushFull | input | 1 | Flush clears the delta instead of restoring it |
| flushTag | input | 3 | Entry to restore on a tagged flush |
| offsetOut | output | 24 | Per-lane signed offset, lane n in bits 8n+7..8n |
| syncValid | output | 3 | Per-lane sync request |
| syncAmount | output | 24 | Per-lane signed amount to add into the base |
| spDelta | output | 8 | Current stored delta |
| baseVer | output | 4 | Current base version |

## Verification
A corrupted delta shows up immediately in the offset of the next stack operation and on the spDelta port one edge later. A wrong chaining order shows as a skewed offset in lane 1 or lane 2 within the same cycle. A missed overflow fold only appears once the delta reaches its edge, so the bench drives runs of 32 or more same-direction operations. A mishandled checkpoint stays hidden until the matching flush, which is why the bench drives the state away from the saved values before it flushes.

// File: rtl/sdt_pkg.sv
package sdt_pkg;
  localparam logic [2:0] KIND_PUSH  = 3'd1;
  localparam logic [2:0] KIND_POP   = 3'd2;
  localparam logic [2:0] KIND_CALL  = 3'd3;
  localparam logic [2:0] KIND_RET   = 3'd4;
  localparam logic [2:0] KIND_SPUSE = 3'd5;

  // per-lane strobes from control to datapath
  typedef struct packed {
    logic dec;
    logic inc;
    logic fold;
  } laneCtl_t;

  // whole-cycle strobes from control to datapath
  typedef struct packed {
    logic restore;
    logic clearAll;
    logic capture;
  } seqCtl_t;
endpackage

// File: rtl/sdt_ctrl.sv
module sdt_ctrl
  import sdt_pkg::*;
#(
  parameter int LANES = 3
) (
  input  logic [LANES-1:0]   slotValid,
  input  logic [LANES*3-1:0] slotKind,
  input  logic               ckptValid,
  input  logic               flushValid,
  input  logic               flushFull,
  output laneCtl_t [LANES-1:0] laneCtl,
  output seqCtl_t            seqCtl
);
  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : gLane
      logic [2:0] kind;
      logic live;
      always_comb begin
        kind = slotKind[g*3 +: 3];
        live = slotValid[g] & ~flushValid;
        laneCtl[g].dec  = live & ((kind == KIND_PUSH) | (kind == KIND_CALL));
        laneCtl[g].inc  = live & ((kind == KIND_POP)  | (kind == KIND_RET));
        laneCtl[g].fold = live & (kind == KIND_SPUSE);
      end
    end
  endgenerate

  always_comb begin
    seqCtl.restore  = flushValid & ~flushFull;
    seqCtl.clearAll = flushValid & flushFull;
    seqCtl.capture  = ckptValid & ~flushValid;
  end
endmodule

// File: rtl/sdt_datapath.sv
module sdt_datapath
  import sdt_pkg::*;
#(
  parameter int LANES = 3,
  parameter int DW    = 8,
  parameter int VW    = 4,
  parameter int TAGS  = 8,
  parameter int STEP  = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  laneCtl_t [LANES-1:0]     laneCtl,
  input  seqCtl_t                  seqCtl,
  input  logic [$clog2(TAGS)-1:0]  ckptTag,
  input  logic [$clog2(TAGS)-1:0]  flushTag,
  output logic [LANES*DW-1:0]      offsetOut,
  output logic [LANES-1:0]         syncValid,
  output logic [LANES*DW-1:0]      syncAmount,
  output logic [DW-1:0]            spDelta,
  output logic [VW-1:0]            baseVer
);
  localparam int CW = $clog2(LANES + 1);
  localparam logic signed [DW:0] LO     = -(2 ** (DW - 1));
  localparam logic signed [DW:0] HI     = (2 ** (DW - 1)) - 1;
  localparam logic signed [DW:0] STEP_S = (DW + 1)'(STEP);

  logic signed [DW-1:0] deltaQ;
  logic [VW-1:0]        verQ;
  logic [DW-1:0]        tblDelta [TAGS];
  logic [VW-1:0]        tblVer   [TAGS];

  logic signed [DW-1:0] run;
  logic signed [DW:0]   stepped;
  logic [CW-1:0]        foldCount;
  logic [DW-1:0]        groupDelta;
  logic [VW-1:0]        groupVer;

  // chained narrow adders, one per lane, in program order
  always_comb begin
    run       = deltaQ;
    stepped   = '0;
    foldCount = '0;
    offsetOut  = '0;
    syncValid  = '0;
    syncAmount = '0;
    for (int i = 0; i < LANES; i++) begin
      if (laneCtl[i].fold) begin
        syncValid[i]             = 1'b1;
        syncAmount[i*DW +: DW]   = run;
        run                      = '0;
        foldCount                = foldCount + CW'(1);
      end else if (laneCtl[i].dec || laneCtl[i].inc) begin
        if (laneCtl[i].dec) stepped = {run[DW-1], run} - STEP_S;
        else                stepped = {run[DW-1], run} + STEP_S;
        if (stepped < LO || stepped > HI) begin
          syncValid[i]           = 1'b1;
          syncAmount[i*DW +: DW] = run;
          run                    = '0;
          foldCount              = foldCount + CW'(1);
          stepped                = laneCtl[i].dec ? -STEP_S : STEP_S;
        end
        offsetOut[i*DW +: DW] = run;
        run                   = stepped[DW-1:0];
      end
    end
    groupDelta = run;
    groupVer   = verQ + VW'(foldCount);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      deltaQ <= '0;
      verQ   <= '0;
      for (int t = 0; t < TAGS; t++) begin
        tblDelta[t] <= '0;
        tblVer[t]   <= '0;
      end
    end else if (seqCtl.restore) begin
      deltaQ <= tblDelta[flushTag];
      verQ   <= tblVer[flushTag];
    end else if (seqCtl.clearAll) begin
      deltaQ <= '0;
    end else begin
      deltaQ <= groupDelta;
      verQ   <= groupVer;
      if (seqCtl.capture) begin
        tblDelta[ckptTag] <= groupDelta;
        tblVer[ckptTag]   <= groupVer;
      end
    end
  end

  assign spDelta = deltaQ;
  assign baseVer = verQ;
endmodule

// File: rtl/stack_delta_tracker.sv
module stack_delta_tracker
  import sdt_pkg::*;
#(
  parameter int LANES = 3,
  parameter int DW    = 8,
  parameter int VW    = 4,
  parameter int TAGS  = 8,
  parameter int STEP  = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [LANES-1:0]        slotValid,
  input  logic [LANES*3-1:0]      slotKind,
  input  logic                    ckptValid,
  input  logic [$clog2(TAGS)-1:0] ckptTag,
  input  logic                    flushValid,
  input  logic                    flushFull,
  input  logic [$clog2(TAGS)-1:0] flushTag,
  output logic [LANES*DW-1:0]     offsetOut,
  output logic [LANES-1:0]        syncValid,
  output logic [LANES*DW-1:0]     syncAmount,
  output logic [DW-1:0]           spDelta,
  output logic [VW-1:0]           baseVer
);
  laneCtl_t [LANES-1:0] laneCtl;
  seqCtl_t              seqCtl;

  sdt_ctrl #(.LANES(LANES)) uCtrl (
    .slotValid (slotValid),
    .slotKind  (slotKind),
    .ckptValid (ckptValid),
    .flushValid(flushValid),
    .flushFull (flushFull),
    .laneCtl   (laneCtl),
    .seqCtl    (seqCtl)
  );

  sdt_datapath #(
    .LANES(LANES), .DW(DW), .VW(VW), .TAGS(TAGS), .STEP(STEP)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .laneCtl   (laneCtl),
    .seqCtl    (seqCtl),
    .ckptTag   (ckptTag),
    .flushTag  (flushTag),
    .offsetOut (offsetOut),
    .syncValid (syncValid),
    .syncAmount(syncAmount),
    .spDelta   (spDelta),
    .baseVer   (baseVer)
  );
endmodule

// File: rtl/sdt_checker.sv
module sdt_checker #(
  parameter int LANES = 3,
  parameter int DW    = 8,
  parameter int VW    = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic [LANES-1:0]    slotValid,
  input logic                flushValid,
  input logic                flushFull,
  input logic [LANES*DW-1:0] offsetOut,
  input logic [LANES-1:0]    syncValid,
  input logic [DW-1:0]       spDelta,
  input logic [VW-1:0]       baseVer
);
  assert_full_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (flushValid && flushFull) |=> (spDelta == '0));

  assert_full_keeps_ver_R8: assert property (@(posedge clk) disable iff (!rstN)
    (flushValid && flushFull) |=> $stable(baseVer));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!flushValid && slotValid == '0) |=> $stable(spDelta));

  assert_ver_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    !flushValid |=> baseVer == VW'($past(baseVer) + $past($countones(syncValid))));

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : gLaneChk
      assert_sync_offset_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
        syncValid[g] |-> (offsetOut[g*DW +: DW] == '0));
    end
  endgenerate
endmodule

bind stack_delta_tracker sdt_checker #(.LANES(LANES), .DW(DW), .VW(VW)) uChk (.*);

// File: tb/stack_delta_tracker_test.sv
module stack_delta_tracker_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  slotValid = '0;
  logic [8:0]  slotKind = '0;
  logic        ckptValid = 1'b0;
  logic [2:0]  ckptTag = '0;
  logic        flushValid = 1'b0;
  logic        flushFull = 1'b0;
  logic [2:0]  flushTag = '0;
  logic [23:0] offsetOut;
  logic [2:0]  syncValid;
  logic [23:0] syncAmount;
  logic [7:0]  spDelta;
  logic [3:0]  baseVer;

  int nChecks = 0;
  int nFails  = 0;

  localparam logic [2:0] PU = 3'd1, PO = 3'd2, CA = 3'd3, RE = 3'd4, SU = 3'd5;

  stack_delta_tracker uut (.*);

  always #2 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int offAt(int l);
    return int'($signed(offsetOut[l*8 +: 8]));
  endfunction

  function automatic int amtAt(int l);
    return int'($signed(syncAmount[l*8 +: 8]));
  endfunction

  // drive a group at the falling edge and let combinational outputs settle
  task automatic drive(logic [2:0] v, logic [2:0] k0, logic [2:0] k1, logic [2:0] k2);
    slotValid = v;
    slotKind  = {k2, k1, k0};
    #1;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    slotValid = '0; slotKind = '0; ckptValid = 1'b0; flushValid = 1'b0; flushFull = 1'b0;
  endtask

  task automatic chkState(string req, int d, int ver);
    chk({req, " delta"}, int'($signed(spDelta)), d);
    chk({req, " version"}, int'(baseVer), ver);
  endtask

  task automatic testReset();
    chkState("R9 reset", 0, 0);
    chk("R9 reset sync", int'(syncValid), 0);
  endtask

  task automatic testChain();
    drive(3'b111, PU, PU, CA);
    chk("R2 lane0 off", offAt(0), 0);
    chk("R2 lane1 off", offAt(1), -4);
    chk("R2 lane2 off", offAt(2), -8);
    chk("R1 no sync", int'(syncValid), 0);
    tick();
    chkState("R1 after push/call", -12, 0);
    drive(3'b011, PO, RE, PU);
    chk("R1 pop off", offAt(0), -12);
    chk("R1 ret off", offAt(1), -8);
    chk("R6 invalid lane off", offAt(2), 0);
    tick();
    chkState("R6 invalid lane ignored", -4, 0);
  endtask

  task automatic testOtherKinds();
    drive(3'b111, 3'd6, 3'd7, 3'd0);
    chk("R6 other kinds sync", int'(syncValid), 0);
    chk("R6 other kinds off", offAt(0) | offAt(1) | offAt(2), 0);
    tick();
    chkState("R6 other kinds", -4, 0);
  endtask

  task automatic testSpUse();
    drive(3'b111, PU, SU, PO);
    chk("R3 lane0 off", offAt(0), -4);
    chk("R3 sync flags", int'(syncValid), 2);
    chk("R3 sync amount", amtAt(1), -8);
    chk("R3 lane1 off", offAt(1), 0);
    chk("R3 lane2 off", offAt(2), 0);
    tick();
    chkState("R3 after fold", 4, 1);
  endtask

  task automatic testCheckpoint();
    ckptValid = 1'b1; ckptTag = 3'd3;
    drive(3'b001, PO, 3'd0, 3'd0);
    tick();
    chkState("R7 capture cycle", 8, 1);
    drive(3'b111, PU, PU, PU);
    tick();
    chkState("R7 drift", -4, 1);
    drive(3'b111, SU, SU, SU);
    chk("R5 three syncs", int'(syncValid), 7);
    chk("R5 first amount", amtAt(0), -4);
    chk("R5 second amount", amtAt(1), 0);
    tick();
    chkState("R5 multi sync", 0, 4);
    flushValid = 1'b1; flushTag = 3'd3;
    drive(3'b001, PU, 3'd0, 3'd0);
    tick();
    chkState("R7 restore", 8, 1);
    flushValid = 1'b1; flushTag = 3'd5;
    drive(3'b000, 3'd0, 3'd0, 3'd0);
    tick();
    chkState("R9 unwritten entry", 0, 0);
  endtask

  task automatic testFullFlush();
    drive(3'b001, PU, 3'd0, 3'd0); tick();
    drive(3'b001, SU, 3'd0, 3'd0); tick();
    drive(3'b001, PU, 3'd0, 3'd0); tick();
    chkState("R8 before flush", -4, 1);
    flushValid = 1'b1; flushFull = 1'b1;
    drive(3'b001, PO, 3'd0, 3'd0);
    tick();
    chkState("R8 full flush", 0, 1);
  endtask

  task automatic testOverflowDown();
    for (int n = 0; n < 10; n++) begin
      drive(3'b111, PU, CA, PU);
      tick();
    end
    chkState("R4 run down", -120, 1);
    drive(3'b111, PU, PU, PU);
    chk("R4 lane0 off", offAt(0), -120);
    chk("R4 lane1 off", offAt(1), -124);
    chk("R4 forced sync", int'(syncValid), 4);
    chk("R4 forced amount", amtAt(2), -128);
    chk("R4 forced off", offAt(2), 0);
    tick();
    chkState("R4 after forced fold", -4, 2);
  endtask

  task automatic testOverflowUp();
    flushValid = 1'b1; flushFull = 1'b1;
    drive(3'b000, 3'd0, 3'd0, 3'd0);
    tick();
    for (int n = 0; n < 10; n++) begin
      drive(3'b111, PO, RE, PO);
      tick();
    end
    chkState("R4 run up", 120, 2);
    drive(3'b111, PO, PO, PO);
    chk("R4 up lane0 off", offAt(0), 120);
    chk("R4 up sync", int'(syncValid), 2);
    chk("R4 up amount", amtAt(1), 124);
    chk("R4 up lane1 off", offAt(1), 0);
    chk("R4 up lane2 off", offAt(2), 4);
    tick();
    chkState("R4 after up fold", 8, 3);
  endtask

  task automatic testWrap();
    for (int n = 0; n < 6; n++) begin
      drive(3'b111, SU, SU, SU);
      tick();
    end
    chkState("R5 version wrap", 0, (3 + 18) % 16);
  endtask

  initial begin
    #(4 * 100000);
    nFails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testChain();
    testOtherKinds();
    testSpUse();
    testCheckpoint();
    testFullFlush();
    testOverflowDown();
    testOverflowUp();
    testWrap();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule